// File: doc/BRIEF.md
# Nonvolatile Shadow Memory Controller

This block fronts a byte-wide static memory that has a second, nonvolatile copy beside it. Each clock it samples a synchronous view of an asynchronous memory bus: chip select, output enable, write strobe, an 11-bit address and 8-bit data, all active-low where they are strobes. It also watches an external save request pin and a supply-good indication. From these it decides when to copy the working memory into the nonvolatile copy (a save) or the nonvolatile copy back into working memory (a restore). It drives an active-low busy line while either operation runs.

A save can come from software, from the request pin or from supply loss. Software triggers a save or a restore by issuing six reads to a fixed list of addresses, with no other access in between. A save from the pin or from supply loss only happens when memory has been written since the last save. A software save always runs. A restore runs after reset, and again when the supply comes back after it was low. Both durations are clock-cycle parameters, and the bus is shut off for the whole of each operation.

Top module: `nvsram_ctrl`

## Requirements
- R1: A read is decoded in a cycle when `ce_n` and `oe_n` are low, `we_n` and `save_req_n` are high, `supply_ok` is high and no operation runs. In that cycle `dout_en` is 1 and `dout` holds the byte last written at `addr`. In every other cycle `dout_en` is 0.
- R2: A write is decoded when `ce_n` and `we_n` are low, `save_req_n` and `supply_ok` are high and no operation runs. It stores `din` at `addr`. `dout_en` stays 0 during a write even when `oe_n` is low.
- R3: Six decoded reads in order to the save list (index 0 first: 0x4E3, 0x1C7, 0x3E0, 0x41F, 0x03F, 0x7C0) start a save. The save starts at the clock edge of the sixth read. It runs whether or not memory was written.
- R4: A decoded access that breaks the order returns the save and restore detectors to their start. A decoded write does this as well. A breaking read that equals the first list address counts as step one of a new sequence.
- R5: Six ordered reads to the restore list (0x4E3, 0x1C7, 0x3E0, 0x41F, 0x03F, 0x4C3) start a restore. The restore clears working memory and then loads it from the nonvolatile copy. The nonvolatile copy is left unchanged, so two restores in a row give the same data.
- R6: A write marks memory as modified, and the start of any save clears that mark. With the mark set, `save_req_n` low starts a save.
- R7: With the mark clear, `save_req_n` low starts no operation. All accesses stay disabled until the pin returns high.
- R8: While `supply_ok` is low, no access is decoded. If the mark is set, a save starts.
- R9: A restore starts after reset is released. A restore also starts once `supply_ok` returns high after having been low, after any running save has finished.
- R10: `busy_n` is low for exactly STORE_CYC (default 64) cycles per save and exactly RECALL_CYC (default 8) cycles per restore. No access is decoded while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not reading |
| dout_en | output | 1 | Output driver enable |
| save_req_n | input | 1 | External save request, active low |
| supply_ok | input | 1 | Supply above threshold |
| busy_n | output | 1 | Open-drain style busy, low while an operation runs |

## Verification
A detector stuck at the wrong step shows at the ports as a missing busy pulse, or a stray one, at the clock edge after the sixth read. A wrong modified mark shows when the pin or the supply-loss path either starts a save it should skip or skips one it should run. Both are visible on `busy_n` within one cycle. A damaged copy path only shows on the first read after the next restore, which returns data other than what was written before the save. The operation length counter is checked by counting busy cycles exactly.

// File: rtl/nv_pkg.sv
package nv_pkg;
  typedef enum logic [1:0] {NV_IDLE, NV_SAVE, NV_RESTORE} nv_mode_e;

  localparam int NV_SEQ_LEN = 6;
  // index 0 at the least significant slice
  localparam logic [NV_SEQ_LEN*11-1:0] NV_SAVE_SEQ =
    {11'h7C0, 11'h03F, 11'h41F, 11'h3E0, 11'h1C7, 11'h4E3};
  localparam logic [NV_SEQ_LEN*11-1:0] NV_RESTORE_SEQ =
    {11'h4C3, 11'h03F, 11'h41F, 11'h3E0, 11'h1C7, 11'h4E3};
endpackage

// File: rtl/nv_seq_det.sv
module nv_seq_det #(
  parameter int AW = 11,
  parameter int LEN = 6,
  parameter logic [LEN*AW-1:0] SEQ = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          fire
);
  localparam int IW = (LEN > 2) ? $clog2(LEN) : 1;

  logic [IW-1:0] step_q, step_d;
  logic [AW-1:0] want, head;

  always_comb begin
    want   = SEQ[int'(step_q)*AW +: AW];
    head   = SEQ[0 +: AW];
    step_d = step_q;
    fire   = 1'b0;
    if (wr) begin
      step_d = '0;
    end else if (rd) begin
      if (addr == want) begin
        if (step_q == IW'(LEN-1)) begin
          fire   = 1'b1;
          step_d = '0;
        end else begin
          step_d = step_q + IW'(1);
        end
      end else begin
        step_d = (addr == head) ? IW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else if (rd || wr) step_q <= step_d;
  end

  assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= IW'(LEN-1));
  assert_fire_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (rd && !wr));
endmodule

// File: rtl/nv_cycle_ctrl.sv
module nv_cycle_ctrl
  import nv_pkg::*;
#(
  parameter int STORE_CYC = 64,
  parameter int RECALL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pin_n,
  input  logic wr,
  input  logic sw_save,
  input  logic sw_restore,
  output logic busy,
  output logic save_start,
  output logic save_end,
  output logic restore_start,
  output logic restore_end
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW = (MAXC > 2) ? $clog2(MAXC) : 1;

  nv_mode_e      mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dirty_q, dirty_d;
  logic          rpend_q, rpend_d;

  always_comb begin
    mode_d        = mode_q;
    cnt_d         = cnt_q;
    save_start    = 1'b0;
    restore_start = 1'b0;
    save_end      = 1'b0;
    restore_end   = 1'b0;
    if (mode_q == NV_IDLE) begin
      if (!supply_ok) begin
        save_start = dirty_q;
      end else if (rpend_q) begin
        restore_start = 1'b1;
      end else if (sw_save) begin
        save_start = 1'b1;
      end else if (sw_restore) begin
        restore_start = 1'b1;
      end else if (!pin_n && dirty_q) begin
        save_start = 1'b1;
      end
      if (save_start) begin
        mode_d = NV_SAVE;
        cnt_d  = CW'(STORE_CYC-1);
      end else if (restore_start) begin
        mode_d = NV_RESTORE;
        cnt_d  = CW'(RECALL_CYC-1);
      end
    end else if (cnt_q == '0) begin
      save_end    = (mode_q == NV_SAVE);
      restore_end = (mode_q == NV_RESTORE);
      mode_d      = NV_IDLE;
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
    dirty_d = save_start ? 1'b0 : (wr ? 1'b1 : dirty_q);
    rpend_d = !supply_ok ? 1'b1 : (restore_start ? 1'b0 : rpend_q);
  end

  assign busy = (mode_q != NV_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= NV_IDLE;
      cnt_q   <= '0;
      dirty_q <= 1'b0;
      rpend_q <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      dirty_q <= dirty_d;
      rpend_q <= rpend_d;
    end
  end

  assert_pin_save_needs_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_start && !sw_save) |-> dirty_q);
  assert_write_marks_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> dirty_q);
  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != NV_IDLE && cnt_q != '0) |=> (mode_q == $past(mode_q)));
  assert_restore_on_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && rpend_q && mode_q == NV_IDLE) |-> restore_start);
endmodule

// File: rtl/nv_arrays.sv
module nv_arrays #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          save_start,
  input  logic          save_end,
  input  logic          restore_start,
  input  logic          restore_end
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] work_mem [DEPTH];
  logic [DW-1:0] keep_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (restore_start)    work_mem <= '{default: '0};
    else if (restore_end) work_mem <= keep_mem;
    else if (wr)          work_mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (save_start)    keep_mem <= '{default: '0};
    else if (save_end) keep_mem <= work_mem;
  end

  assign rdata = work_mem[addr];
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nv_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int STORE_CYC = 64,
  parameter int RECALL_CYC = 8,
  parameter logic [NV_SEQ_LEN*AW-1:0] SAVE_SEQ = NV_SAVE_SEQ,
  parameter logic [NV_SEQ_LEN*AW-1:0] RESTORE_SEQ = NV_RESTORE_SEQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          save_req_n,
  input  logic          supply_ok,
  output logic          busy_n
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       busy, bus_ok, rd, wr;
  logic       sw_save, sw_restore;
  logic       save_start, save_end, restore_start, restore_end;
  logic [DW-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign bus_ok = supply_ok && !busy && save_req_n && !ce_n;
  assign rd     = bus_ok && !oe_n && we_n;
  assign wr     = bus_ok && !we_n;

  nv_seq_det #(.AW(AW), .LEN(NV_SEQ_LEN), .SEQ(SAVE_SEQ)) u_save_det (
    .clk(clk), .rst_n(rst_i_n), .rd(rd), .wr(wr), .addr(addr), .fire(sw_save));

  nv_seq_det #(.AW(AW), .LEN(NV_SEQ_LEN), .SEQ(RESTORE_SEQ)) u_restore_det (
    .clk(clk), .rst_n(rst_i_n), .rd(rd), .wr(wr), .addr(addr), .fire(sw_restore));

  nv_cycle_ctrl #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .supply_ok(supply_ok), .pin_n(save_req_n),
    .wr(wr), .sw_save(sw_save), .sw_restore(sw_restore), .busy(busy),
    .save_start(save_start), .save_end(save_end),
    .restore_start(restore_start), .restore_end(restore_end));

  nv_arrays #(.AW(AW), .DW(DW)) u_arrays (
    .clk(clk), .wr(wr), .addr(addr), .wdata(din), .rdata(rdata),
    .save_start(save_start), .save_end(save_end),
    .restore_start(restore_start), .restore_end(restore_end));

  assign dout_en = rd;
  assign dout    = rd ? rdata : '0;
  assign busy_n  = !busy;

  assert_no_drive_in_write_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    dout_en |-> we_n);
  assert_no_access_busy_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy_n |-> !dout_en);
  assert_no_access_low_supply_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !supply_ok |-> !dout_en);
  assert_pin_low_blocks_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !save_req_n |-> !dout_en);
endmodule

// File: tb/nvsram_ctrl_bench.sv
module nvsram_ctrl_bench;
  import nv_pkg::*;

  localparam int CLK_T = 10;
  localparam int SAVE_N = 64;
  localparam int REST_N = 8;

  logic        clk = 1'b0;
  logic        rst_n, ce_n, oe_n, we_n, save_req_n, supply_ok;
  logic [10:0] addr;
  logic [7:0]  din, dout;
  logic        dout_en, busy_n;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_T/2) clk = ~clk;

  nvsram_ctrl u_nvsram_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .save_req_n(save_req_n), .supply_ok(supply_ok), .busy_n(busy_n));

  // {write, addr[10:0], data, expected read}
  localparam logic [27:0] VEC [8] = '{
    {1'b1, 11'h010, 8'hA5, 8'h00},
    {1'b1, 11'h7FF, 8'h3C, 8'h00},
    {1'b1, 11'h000, 8'h01, 8'h00},
    {1'b0, 11'h010, 8'h00, 8'hA5},
    {1'b0, 11'h7FF, 8'h00, 8'h3C},
    {1'b1, 11'h010, 8'h5A, 8'h00},
    {1'b0, 11'h010, 8'h00, 8'h5A},
    {1'b0, 11'h000, 8'h00, 8'h01}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
    @(posedge clk);
  endtask

  task automatic do_read(input logic [10:0] a, input bit chk, input logic [7:0] e,
                         input string tag);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1;
    if (chk) begin
      check({tag, " dout_en"}, int'(dout_en), 1);
      check({tag, " dout"}, int'(dout), int'(e));
    end
    @(posedge clk);
  endtask

  task automatic run_seq(input logic [NV_SEQ_LEN*11-1:0] s);
    for (int i = 0; i < NV_SEQ_LEN; i++) do_read(s[i*11 +: 11], 1'b0, 8'h00, "");
  endtask

  // counts busy cycles, optionally reading meanwhile; checks output gating
  task automatic measure(input bit rd_on, input string tag, output int n);
    int wait_c = 0;
    bit seen = 1'b0;
    n = 0;
    while (1) begin
      @(negedge clk);
      ce_n = !rd_on; oe_n = !rd_on; we_n = 1'b1; addr = 11'h010;
      #1;
      check({tag, " output gating"}, int'(dout_en),
            int'(rd_on && busy_n && save_req_n && supply_ok));
      if (!busy_n) begin
        seen = 1'b1; n++;
      end else if (seen) begin
        break;
      end else begin
        wait_c++;
        if (wait_c > 6) break;
      end
    end
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    #(CLK_T * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    save_req_n = 1'b1; supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset busy_n", int'(busy_n), 1);
    check("R1 reset dout_en", int'(dout_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    measure(1'b0, "R9 power-up restore", n);
    check("R9 power-up restore length", n, REST_N);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][27]) do_write(VEC[i][26:16], VEC[i][15:8]);
      else do_read(VEC[i][26:16], 1'b1, VEC[i][7:0], "R1 vector read");
    end

    // software save while reading during busy
    run_seq(NV_SAVE_SEQ);
    measure(1'b1, "R10 sw save", n);
    check("R3 R10 sw save length", n, SAVE_N);

    // restore twice gives saved data
    do_write(11'h010, 8'hEE);
    do_read(11'h010, 1'b1, 8'hEE, "R2 write");
    run_seq(NV_RESTORE_SEQ);
    measure(1'b0, "R5 restore", n);
    check("R5 restore length", n, REST_N);
    do_read(11'h010, 1'b1, 8'h5A, "R5 restored");
    run_seq(NV_RESTORE_SEQ);
    measure(1'b0, "R5 restore again", n);
    do_read(11'h7FF, 1'b1, 8'h3C, "R5 copy unchanged");

    // stray write aborts the sequence
    do_write(11'h100, 8'h11);
    for (int i = 0; i < 3; i++) do_read(NV_SAVE_SEQ[i*11 +: 11], 1'b0, 8'h00, "");
    do_write(11'h101, 8'h22);
    for (int i = 3; i < 6; i++) do_read(NV_SAVE_SEQ[i*11 +: 11], 1'b0, 8'h00, "");
    measure(1'b0, "R4 aborted", n);
    check("R4 aborted sequence busy", n, 0);

    // repeated first address restarts at step one
    do_read(NV_SAVE_SEQ[10:0], 1'b0, 8'h00, "");
    run_seq(NV_SAVE_SEQ);
    measure(1'b0, "R4 restart", n);
    check("R4 restart sequence save", n, SAVE_N);

    // software save with nothing written still runs
    run_seq(NV_SAVE_SEQ);
    measure(1'b0, "R3 clean", n);
    check("R3 clean sw save length", n, SAVE_N);

    // pin request while clean: nothing, but bus blocked
    @(negedge clk); save_req_n = 1'b0;
    measure(1'b1, "R7 pin clean", n);
    check("R7 pin clean busy", n, 0);
    @(negedge clk); save_req_n = 1'b1;

    // pin request while modified
    do_write(11'h020, 8'h77);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; save_req_n = 1'b0;
    measure(1'b0, "R6 pin", n);
    check("R6 pin save length", n, SAVE_N);
    @(negedge clk); save_req_n = 1'b1;
    do_write(11'h020, 8'h11);
    run_seq(NV_RESTORE_SEQ);
    measure(1'b0, "R6 restore", n);
    do_read(11'h020, 1'b1, 8'h77, "R6 pin save data");

    // supply loss while modified
    do_write(11'h030, 8'hC3);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; supply_ok = 1'b0;
    measure(1'b1, "R8 supply save", n);
    check("R8 supply save length", n, SAVE_N);
    measure(1'b1, "R8 supply low idle", n);
    check("R8 no second save", n, 0);
    @(negedge clk); supply_ok = 1'b1;
    measure(1'b0, "R9 supply return", n);
    check("R9 supply return restore length", n, REST_N);
    do_read(11'h030, 1'b1, 8'hC3, "R8 saved on loss");
    do_read(11'h020, 1'b1, 8'h77, "R9 restored");

    // supply loss while clean: no save, restore on return
    go_idle(); supply_ok = 1'b0;
    measure(1'b1, "R8 clean loss", n);
    check("R8 clean loss save", n, 0);
    @(negedge clk); supply_ok = 1'b1;
    measure(1'b0, "R9 clean return", n);
    check("R9 clean return restore", n, REST_N);

    // write with output enable low keeps outputs off
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 11'h040; din = 8'h9C;
    #1;
    check("R2 no output during write", int'(dout_en), 0);
    @(posedge clk);
    do_read(11'h040, 1'b1, 8'h9C, "R2 write with oe low");
    go_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule